// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block sits between eight level-sensitive device request lines and a processor. It keeps the level the processor currently runs at, finds the highest pending request, and raises an interrupt request only when that request strictly outranks the running level. Ordinary program code runs at level 0, and each handler runs at the level of its own device. For example, a disk could sit on line 7 and a keyboard on line 4.

When the processor acknowledges, the arbiter saves the running level on an internal stack of saved levels and switches to the granted level. A higher request can therefore preempt a running handler. A return pulse from the handler restores the most recently saved level. A write port lets software load the running level directly, for example to shut out interrupts during a critical section.

Top module: `prio_irq_nest`

## Requirements
- R1: After reset, irq_o is 0, vec_o is 0 and cur_lvl_o is 0.
- R2: If request line L (1 to 7) is high and L is greater than cur_lvl_o, and no ack, return or write is applied, then irq_o is 1 and vec_o equals L one clock later.
- R3: A request whose line number is equal to or lower than cur_lvl_o does not raise irq_o. Line 0 never raises irq_o.
- R4: When several lines are high, the highest-numbered line is the one that is granted.
- R5: While irq_o is high, vec_o stays unchanged until an ack or a write, even if the request lines change or a return is applied.
- R6: An ack while irq_o is high pushes cur_lvl_o onto the stack. One clock later cur_lvl_o equals the granted vec_o and irq_o is 0.
- R7: A request above the level of a running handler raises irq_o, so handlers can nest.
- R8: A return pulse restores the level saved by the matching ack, in last-in, first-out order.
- R9: A return pulse when the stack is empty sets cur_lvl_o to 0.
- R10: A write loads wr_lvl_i into cur_lvl_o and withdraws any pending irq_o. An ack while irq_o is low is ignored. In one cycle, ack (with irq_o high) takes precedence over return, and return takes precedence over write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Level-sensitive request lines; bit n is priority level n |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| ret_i | input | 1 | Return-from-handler pulse |
| wr_en_i | input | 1 | Software write strobe for the running level |
| wr_lvl_i | input | 3 | Level to load on a write |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Level number of the granted request |
| cur_lvl_o | output | 3 | Level the processor is running at |

## Verification
Two situations are hard to reach from the ports. The first is a return that arrives while a new request is still waiting for its ack. The second is a write that cancels a pending request. The stimulus reaches both by first granting a request, leaving it un-acknowledged, and then applying the return or the write in that window. The sequence also builds a two-deep nest (level 4, then level 7) by holding both lines high across an ack. It then unwinds the nest and issues a further return on the empty stack.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    parameter int NUM_LVL = 8;
    parameter int LVL_W   = $clog2(NUM_LVL);

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t cur;
        logic irq;
        lvl_t vec;
    } arb_st_t;
endpackage

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
    import prio_irq_pkg::*;
(
    input  logic [NUM_LVL-1:0] req_i,
    output logic               valid_o,
    output lvl_t               lvl_o
);
    // Scan upward so that the highest set line is the last one written.
    always_comb begin
        lvl_o = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (req_i[i]) lvl_o = LVL_W'(i);
        end
        // Line 0 can never outrank anything, so it alone does not count.
        valid_o = (lvl_o != '0);
    end
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack
    import prio_irq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic pop_i,
    input  lvl_t push_val_i,
    output lvl_t top_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][LVL_W-1:0] mem;
        logic [CW-1:0]               cnt;
    } stk_st_t;

    stk_st_t st_d, st_q;
    logic [IW-1:0] top_idx;

    assign top_idx = IW'(st_q.cnt - 1'b1);
    assign top_o   = (st_q.cnt == '0) ? '0 : st_q.mem[top_idx];

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            if (st_q.cnt == CW'(DEPTH)) begin
                // Full: the newest saved level replaces the topmost entry.
                st_d.mem[DEPTH-1] = push_val_i;
            end else begin
                st_d.mem[IW'(st_q.cnt)] = push_val_i;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (pop_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && st_q.cnt == '0) |=> (st_q.cnt == '0 && top_o == '0));
endmodule

// File: rtl/prio_irq_nest.sv
module prio_irq_nest
    import prio_irq_pkg::*;
#(
    parameter int STK_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] req_i,
    input  logic               ack_i,
    input  logic               ret_i,
    input  logic               wr_en_i,
    input  logic [LVL_W-1:0]   wr_lvl_i,
    output logic               irq_o,
    output logic [LVL_W-1:0]   vec_o,
    output logic [LVL_W-1:0]   cur_lvl_o
);
    arb_st_t st_d, st_q;
    logic    pick_valid;
    lvl_t    pick_lvl;
    lvl_t    stk_top;
    logic    push, pop;
    logic    win;

    prio_irq_pick u_pick (
        .req_i   (req_i),
        .valid_o (pick_valid),
        .lvl_o   (pick_lvl)
    );

    prio_irq_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_val_i (st_q.cur),
        .top_o      (stk_top)
    );

    assign win = pick_valid && (pick_lvl > st_q.cur);

    always_comb begin
        st_d = st_q;
        push = 1'b0;
        pop  = 1'b0;
        if (st_q.irq && ack_i) begin
            push     = 1'b1;
            st_d.cur = st_q.vec;
            st_d.irq = 1'b0;
        end else if (ret_i) begin
            pop      = 1'b1;
            st_d.cur = stk_top;
        end else if (wr_en_i) begin
            st_d.cur = wr_lvl_i;
            st_d.irq = 1'b0;
        end else if (!st_q.irq && win) begin
            st_d.irq = 1'b1;
            st_d.vec = pick_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o     = st_q.irq;
    assign vec_o     = st_q.vec;
    assign cur_lvl_o = st_q.cur;

    // R2
    irq_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (vec_o > cur_lvl_o));

    // R5
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i && !wr_en_i) |=> (irq_o && $stable(vec_o)));

    // R6
    ack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> (!irq_o && cur_lvl_o == $past(vec_o)));

    // R10
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !ret_i && !(irq_o && ack_i)) |=> (!irq_o && cur_lvl_o == $past(wr_lvl_i)));
endmodule

// File: tb/prio_irq_nest_tb.sv
`timescale 1ns/1ps
module prio_irq_nest_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req;
    logic       ack, ret, wr;
    logic [2:0] wl;
    logic       irq;
    logic [2:0] vec, cur;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       irq;
        logic [2:0] vec;
        logic [2:0] cur;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    prio_irq_nest u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack), .ret_i(ret),
        .wr_en_i(wr), .wr_lvl_i(wl), .irq_o(irq), .vec_o(vec), .cur_lvl_o(cur)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (irq !== e.irq || vec !== e.vec || cur !== e.cur) begin
            errors++;
            $display("FAIL %s: got irq=%0b vec=%0d cur=%0d, expected irq=%0b vec=%0d cur=%0d",
                     e.tag, irq, vec, cur, e.irq, e.vec, e.cur);
        end
    endtask

    // Driver: apply one cycle of stimulus, then queue the state expected after that edge.
    task automatic step(input logic [7:0] r, input logic a, input logic rt,
                        input logic w, input logic [2:0] l,
                        input logic ei, input logic [2:0] ev, input logic [2:0] ec,
                        input string tag);
        exp_t e;
        @(negedge clk);
        req = r; ack = a; ret = rt; wr = w; wl = l;
        @(posedge clk);
        e.irq = ei; e.vec = ev; e.cur = ec; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare at the falling edge that follows each queued edge.
    always @(negedge clk) begin
        while (sb.size() > 0) compare(sb.pop_front());
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t e;
        rst_n = 1'b0; req = '0; ack = 0; ret = 0; wr = 0; wl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        e.irq = 0; e.vec = 0; e.cur = 0; e.tag = "R1 reset state";
        compare(e);
        rst_n = 1'b1;

        step(8'b0000_0001, 0,0,0,0, 0,0,0, "R3 line 0 ignored");
        step(8'b0001_0000, 0,0,0,0, 1,4,0, "R2 level 4 over 0");
        step(8'b1001_0000, 0,0,0,0, 1,4,0, "R5 vector held while 7 arrives");
        step(8'b1001_0000, 1,0,0,0, 0,4,4, "R6 ack loads 4");
        step(8'b1001_0000, 0,0,0,0, 1,7,4, "R7 level 7 preempts handler 4");
        step(8'b1001_0000, 1,0,0,0, 0,7,7, "R6 ack loads 7");
        step(8'b1001_0000, 0,0,0,0, 0,7,7, "R3 equal level stays pending");
        step(8'b0000_0000, 0,1,0,0, 0,7,4, "R8 return to 4");
        step(8'b0000_0000, 0,1,0,0, 0,7,0, "R8 return to 0");
        step(8'b0000_0000, 0,1,0,0, 0,7,0, "R9 return on empty stack");
        step(8'b0010_0110, 0,0,0,0, 1,5,0, "R4 highest of 5,2,1");
        step(8'b0000_0000, 1,0,0,0, 0,5,5, "R6 ack loads 5");
        step(8'b0000_0000, 0,0,1,2, 0,5,2, "R10 write level 2");
        step(8'b0000_1000, 0,0,0,0, 1,3,2, "R2 level 3 over 2");
        step(8'b0000_1000, 0,0,1,6, 0,3,6, "R10 write withdraws pending");
        step(8'b0000_1000, 0,0,0,0, 0,3,6, "R3 lower level ignored");
        step(8'b0000_1000, 1,0,0,0, 0,3,6, "R10 ack without irq ignored");
        step(8'b0000_1000, 0,1,0,0, 0,3,0, "R8 return to saved 0");
        step(8'b0000_1000, 0,0,0,0, 1,3,0, "R2 level 3 over 0");
        step(8'b0000_0000, 0,1,0,0, 1,3,0, "R5 return keeps pending vector");
        step(8'b0000_0000, 1,0,0,0, 0,3,3, "R6 ack loads 3");
        step(8'b0000_0000, 0,1,0,0, 0,3,0, "R9 return empties stack");
        step(8'b0100_0000, 0,0,0,0, 1,6,0, "R2 level 6 over 0");
        step(8'b0000_0000, 1,0,1,1, 0,6,6, "R10 ack wins over write");
        step(8'b0000_0000, 0,1,1,5, 0,6,0, "R10 return wins over write");

        @(negedge clk);
        req = '0; ack = 0; ret = 0; wr = 0;
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule